// File: doc/BRIEF.md
# Two-Level External Interrupt Arbiter

This block collects eight interrupt sources for an 8-bit CPU core and arbitrates among them. It names the highest-ranked request that may be taken to the CPU as an entry address. Six sources come from elsewhere in the chip as request, enable and priority inputs. The two others are extra active-low interrupt pins. Each extra pin has a trigger-type bit, a flag bit, an enable bit and a priority bit, and all eight bits sit in one 8-bit control register. Software can write that register as a whole byte or one bit at a time.

Arbitration uses two priority levels. Any request at the upper level beats every request at the lower level. Inside one level, a fixed polling order settles ties. The block keeps a record of which levels are in service. A lower-level service can be interrupted by an upper-level request, and nothing can interrupt an upper-level service. The CPU accepts the offered interrupt with an acknowledge input and ends a handler with a return input.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, `irq_valid` is low and neither priority level is in service.
- R2: The control register holds four bits for each extra pin, at a base of bit 0 for pin A and bit 4 for pin B. Inside each group: +0 is the trigger type, +1 is the flag, +2 is the enable and +3 is the priority. A byte write loads all 8 bits, and a bit write changes only the bit that `bit_sel` selects.
- R3: When the trigger bit is 1, a falling edge on the pin sets its flag. A falling edge is the pin sampled high on one clock and low on the next. The flag reads back 1 one clock after the low sample.
- R4: An edge-mode flag is cleared when the CPU acknowledges that pin's interrupt. A pin that stays low does not set the flag again.
- R5: When the trigger bit is 0, the pin requests for as long as it is low and stops when it goes high. Its flag reads 0 whatever is written to it.
- R6: A source whose enable is 0 never produces `irq_valid`.
- R7: The entry address for source index k is 0x03 + 8*k. The index order is ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5, pin A=6, pin B=7, which gives addresses 0x03 to 0x3B.
- R8: A request whose priority bit is 1 wins over every request whose priority bit is 0, whatever their indices.
- R9: Among requests at the same level, the lowest index wins.
- R10: While a low-level service is active, low-level requests are held off and high-level requests still get through. While a high-level service is active, all requests are held off.
- R11: A return ends the most recent service: the high level if it is active, otherwise the low level.
- R12: The outputs are registered and follow the inputs by one clock. An acknowledge drops `irq_valid` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Byte write strobe for the control register |
| cfg_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Bit index for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| cfg_rdata | output | 8 | Control register contents |
| pin_n | input | 2 | Extra interrupt pins, active low (bit 0 = pin A, bit 1 = pin B) |
| core_req | input | 6 | Requests of sources 0 to 5 |
| core_en | input | 6 | Enables of sources 0 to 5 |
| core_pri | input | 6 | Priority bits of sources 0 to 5 (1 = high level) |
| irq_ack | input | 1 | CPU accepts the offered interrupt |
| irq_ret | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | 8 | Entry address of the offered interrupt (0 when none) |

## Verification
The assertions assume three things about the CPU side. It acknowledges only while `irq_valid` is high. It never raises acknowledge and return in the same clock. It raises return only while a service level is active. The bench drives every acknowledge and return as a one-clock pulse, issued only after it has seen a valid offer or after a matching acknowledge. It changes core requests and pins on the falling clock edge, and it never writes a trigger bit in the same clock as a pin edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NCORE    = 6;
  localparam int NPIN     = 2;
  localparam int NSRC     = NCORE + NPIN;
  localparam int GRP      = 4;
  localparam int CFG_W    = GRP * NPIN;
  localparam int OFS_TRIG = 0;
  localparam int OFS_FLAG = 1;
  localparam int OFS_EN   = 2;
  localparam int OFS_PRI  = 3;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
endpackage

// File: rtl/xirq_pin.sv
module xirq_pin (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall,
  output logic lvl
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_n;
  end

  assign fall = prev_q & ~pin_n;
  assign lvl  = ~pin_n;
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg
  import xirq_pkg::*;
#(
  parameter int NP = NPIN,
  localparam int W  = GRP * NP,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [W-1:0]  cfg_wdata,
  input  logic          bit_wr,
  input  logic [SW-1:0] bit_sel,
  input  logic          bit_val,
  input  logic [NP-1:0] fall,
  input  logic [NP-1:0] clr,
  output logic [W-1:0]  cfg_q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = cfg_q;
    if (cfg_wr) nxt = cfg_wdata;
    if (bit_wr) nxt[bit_sel] = bit_val;
    for (int p = 0; p < NP; p++) begin
      if (clr[p])                           nxt[GRP*p+OFS_FLAG] = 1'b0;
      if (fall[p] && nxt[GRP*p+OFS_TRIG])   nxt[GRP*p+OFS_FLAG] = 1'b1;
      if (!nxt[GRP*p+OFS_TRIG])             nxt[GRP*p+OFS_FLAG] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= nxt;
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (fall[p] && cfg_q[GRP*p+OFS_TRIG] && !cfg_wr && !bit_wr) |=> cfg_q[GRP*p+OFS_FLAG]); // R3
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (clr[p] && !fall[p] && !cfg_wr && !bit_wr) |=> !cfg_q[GRP*p+OFS_FLAG]); // R4
  end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb
  import xirq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int VW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  pri,
  input  logic          ack,
  input  logic          ret,
  output logic          valid,
  output logic [VW-1:0] vector,
  output logic          svc_fire,
  output logic [IW-1:0] svc_idx
);
  logic          act_hi, act_lo;
  logic [N-1:0]  hi_ok, lo_ok;
  logic [IW-1:0] hi_idx, lo_idx;
  logic          cand_v, cand_hi;
  logic [IW-1:0] cand_idx;
  logic          hi_q;
  logic [IW-1:0] idx_q;

  always_comb begin
    hi_ok  = req & pri & {N{!act_hi}};
    lo_ok  = req & ~pri & {N{!act_hi && !act_lo}};
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hi_ok[i]) hi_idx = IW'(i);
      if (lo_ok[i]) lo_idx = IW'(i);
    end
    cand_v   = |hi_ok || |lo_ok;
    cand_hi  = |hi_ok;
    cand_idx = cand_hi ? hi_idx : lo_idx;
  end

  assign svc_fire = ack && valid;
  assign svc_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      vector <= '0;
      hi_q   <= 1'b0;
      idx_q  <= '0;
    end else if (svc_fire) begin
      valid  <= 1'b0;
      vector <= '0;
    end else begin
      valid  <= cand_v;
      vector <= cand_v ? VW'(VEC_BASE + VEC_STEP * int'(cand_idx)) : '0;
      hi_q   <= cand_hi;
      idx_q  <= cand_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      if (ret) begin
        if (act_hi) act_hi <= 1'b0;
        else        act_lo <= 1'b0;
      end
      if (svc_fire) begin
        if (hi_q) act_hi <= 1'b1;
        else      act_lo <= 1'b1;
      end
    end
  end

  AST_LOW_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (valid && !hi_q) |-> (!act_lo && !act_hi)); // R10
  AST_HIGH_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    valid |-> !act_hi); // R10
  AST_ACK_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    svc_fire |=> !valid); // R12
  AST_ACK_PUSHES_HI: assert property (@(posedge clk) disable iff (rst)
    (svc_fire && hi_q) |=> act_hi); // R10
  AST_RET_POPS_HI: assert property (@(posedge clk) disable iff (rst)
    (ret && act_hi && !ack) |=> (!act_hi && act_lo == $past(act_lo))); // R11
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             bit_wr,
  input  logic [2:0]       bit_sel,
  input  logic             bit_val,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [NPIN-1:0]  pin_n,
  input  logic [NCORE-1:0] core_req,
  input  logic [NCORE-1:0] core_en,
  input  logic [NCORE-1:0] core_pri,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_valid,
  output logic [7:0]       irq_vector
);
  localparam int IW = $clog2(NSRC);

  logic [NPIN-1:0]  fall, lvl, clr, ext_req, ext_pri;
  logic [CFG_W-1:0] cfg_q;
  logic             svc_fire;
  logic [IW-1:0]    svc_idx;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    xirq_pin u_pin (
      .clk  (clk),
      .rst  (rst),
      .pin_n(pin_n[p]),
      .fall (fall[p]),
      .lvl  (lvl[p])
    );
    assign ext_req[p] = cfg_q[GRP*p+OFS_EN] &
                        (cfg_q[GRP*p+OFS_TRIG] ? cfg_q[GRP*p+OFS_FLAG] : lvl[p]);
    assign ext_pri[p] = cfg_q[GRP*p+OFS_PRI];
    assign clr[p]     = svc_fire && (svc_idx == IW'(NCORE + p));
  end

  xirq_cfg #(.NP(NPIN)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .bit_wr   (bit_wr),
    .bit_sel  (bit_sel),
    .bit_val  (bit_val),
    .fall     (fall),
    .clr      (clr),
    .cfg_q    (cfg_q)
  );

  xirq_arb #(.N(NSRC), .VW(8)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     ({ext_req, core_req & core_en}),
    .pri     ({ext_pri, core_pri}),
    .ack     (irq_ack),
    .ret     (irq_ret),
    .valid   (irq_valid),
    .vector  (irq_vector),
    .svc_fire(svc_fire),
    .svc_idx (svc_idx)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       bit_wr = 1'b0;
  logic [2:0] bit_sel = '0;
  logic       bit_val = 1'b0;
  logic [7:0] cfg_rdata;
  logic [1:0] pin_n = 2'b11;
  logic [5:0] core_req = '0;
  logic [5:0] core_en = '0;
  logic [5:0] core_pri = '0;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_valid;
  logic [7:0] irq_vector;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .bit_wr(bit_wr), .bit_sel(bit_sel), .bit_val(bit_val), .cfg_rdata(cfg_rdata),
    .pin_n(pin_n), .core_req(core_req), .core_en(core_en), .core_pri(core_pri),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; step(); cfg_wr = 1'b0;
  endtask

  task automatic wr_bit(int s, logic v);
    bit_wr = 1'b1; bit_sel = 3'(s); bit_val = v; step(); bit_wr = 1'b0;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  task automatic ret_pulse();
    irq_ret = 1'b1; step(); irq_ret = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cfg after reset", int'(cfg_rdata), 'h00);
    chk("R1 valid after reset", int'(irq_valid), 0);
  endtask

  task automatic t_regs();
    wr_byte(8'hA5);   // level mode on pin B forces its flag (bit 5) to 0
    chk("R2/R5 byte write", int'(cfg_rdata), 'h85);
    wr_bit(3, 1'b1);
    chk("R2 bit write set", int'(cfg_rdata), 'h8D);
    wr_bit(7, 1'b0);
    chk("R2 bit write clear", int'(cfg_rdata), 'h0D);
    wr_byte(8'h00);
  endtask

  task automatic t_edge();
    wr_byte(8'h05);   // pin A: edge trigger, enabled
    pin_n[0] = 1'b0;
    step();
    chk("R3 flag set on fall", int'(cfg_rdata), 'h07);
    chk("R12 valid lags flag", int'(irq_valid), 0);
    step();
    chk("R3 valid from flag", int'(irq_valid), 1);
    chk("R7 vector pin A", int'(irq_vector), 'h33);
    ack_pulse();
    chk("R4 flag cleared by ack", int'(cfg_rdata), 'h05);
    chk("R12 valid drops after ack", int'(irq_valid), 0);
    ret_pulse();
    step(2);
    chk("R4 held low pin no retrigger", int'(irq_valid), 0);
    pin_n[0] = 1'b1;
    step();
    wr_byte(8'h00);
  endtask

  task automatic t_level();
    wr_byte(8'h40);   // pin B: level trigger, enabled
    pin_n[1] = 1'b0;
    step();
    chk("R5 level request", int'(irq_valid), 1);
    chk("R7 vector pin B", int'(irq_vector), 'h3B);
    chk("R5 flag stays clear", int'(cfg_rdata), 'h40);
    pin_n[1] = 1'b1;
    step();
    chk("R5 request follows pin", int'(irq_valid), 0);
    wr_byte(8'h00);
    pin_n[1] = 1'b0;
    step(2);
    chk("R6 disabled pin", int'(irq_valid), 0);
    pin_n[1] = 1'b1;
    core_en = 6'b111011;
    core_req = 6'b000100;
    step(2);
    chk("R6 disabled core source", int'(irq_valid), 0);
    core_req = '0;
    core_en = '0;
    step();
  endtask

  task automatic t_order();
    core_en = 6'b111111;
    core_pri = '0;
    core_req = 6'b111110;
    step();
    chk("R9 timer0 first", int'(irq_vector), 'h0B);
    core_req = 6'b110000;
    step();
    chk("R9 serial before timer2", int'(irq_vector), 'h23);
    core_req = '0;
    wr_byte(8'h44);   // both pins level, enabled, low priority
    pin_n = 2'b00;
    step();
    chk("R9 pin A before pin B", int'(irq_vector), 'h33);
    pin_n = 2'b11;
    wr_byte(8'h00);
    step();
  endtask

  task automatic t_pri();
    core_req = 6'b000011;
    core_pri = 6'b000010;
    step();
    chk("R8 high timer0 over low ext0", int'(irq_vector), 'h0B);
    core_req = 6'b111111;
    core_pri = '0;
    wr_byte(8'hC4);   // pin B high priority, pin A low
    pin_n = 2'b00;
    step();
    chk("R8 high pin B over all low", int'(irq_vector), 'h3B);
    pin_n = 2'b11;
    core_req = '0;
    wr_byte(8'h00);
    step();
  endtask

  task automatic t_nest();
    core_en = 6'b111111;
    core_pri = 6'b000010;
    core_req = 6'b000001;
    step();
    chk("R7 vector ext0", int'(irq_vector), 'h03);
    core_req = 6'b000000;
    ack_pulse();
    core_req = 6'b000100;
    step(2);
    chk("R10 low blocked by low", int'(irq_valid), 0);
    core_req = 6'b000110;
    step();
    chk("R10 high preempts low", int'(irq_vector), 'h0B);
    core_req = 6'b000100;
    ack_pulse();
    core_req = 6'b000110;
    step(2);
    chk("R10 all blocked by high", int'(irq_valid), 0);
    core_req = 6'b000100;
    ret_pulse();
    step(2);
    chk("R11 first return leaves low", int'(irq_valid), 0);
    ret_pulse();
    step();
    chk("R11 second return frees low", int'(irq_valid), 1);
    chk("R11 ext1 vector", int'(irq_vector), 'h13);
    core_req = '0;
    ack_pulse();
    ret_pulse();
    step();
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_order();
    t_pri();
    t_nest();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule